// File: doc/BRIEF.md
# Bus Failure Diagnostic Flag Unit

This block derives a set of diagnostic flags for a differential bus line driver from purely digital evidence: the transmit and receive data lines, eight current comparators (one low-current and one high-current comparator for each of the four output drivers), a comparator for a short between the two lines, and the two transmit-enable controls. Flags are only updated while the device is in normal mode and the driver is actually enabled. Every current flag is a sample taken at the end of a qualification window, counted from the last transmit-data edge, so a flag only reflects a steady driven level.

Two small state machines do the sequencing. The echo checker (states `ECHO_IDLE` and `ECHO_PEND`, one copy per edge polarity) checks that each transmit edge comes back on the receive line. `ECHO_IDLE` goes to `ECHO_PEND` on a transmit edge without a receive edge. `ECHO_PEND` returns to `ECHO_IDLE` on a receive edge and stays in `ECHO_PEND` on a further transmit edge. The enable watchdog has three states: `TMO_IDLE`, `TMO_ARMED` and `TMO_EXPIRED`. `TMO_IDLE` goes to `TMO_ARMED` when the driver is enabled. `TMO_ARMED` falls back to `TMO_IDLE` on any enable toggle or when the enable is lost, and goes to `TMO_EXPIRED` once the count runs out. `TMO_EXPIRED` returns to `TMO_IDLE` on an enable toggle or when normal mode is left. Per-line fault classes are formed from pairs of current flags. All error conditions are ORed into a summary, which drives an active-low error pin in normal mode.

Top module: `bfd_flag_unit`

## Requirements
- R1: While `rst_n` is low, or while `mode` is 00 (power off), every flag output is clear on the following cycle. `mode` encodings: 00 off, 01 standby, 10 normal, 11 treated as standby.
- R2: While the driver is enabled, two transmit edges of the same polarity with no receive edge of that polarity between them set `bus_err`. Both lines pass through a two-flop synchronizer before edge detection, and both idle high.
- R3: `bus_err` clears when a transmit edge is followed by a receive edge of the same polarity before the next transmit edge of that polarity. A receive edge arriving in the same cycle as the transmit edge counts as its echo.
- R4: When `drv_en` is low (standby, or transmit enable or guardian enable inactive, or timeout) in any mode other than off, no flag changes.
- R5: Driver index order for `lo_flag` and `hi_flag` is bit 0 line-plus high side, bit 1 line-plus low side, bit 2 line-minus high side, bit 3 line-minus low side. When TxD has been high (Data1) for `BUS_ERR_CYC` cycles since its last edge, bits 0 and 3 of both flag vectors are loaded from the matching comparator inputs.
- R6: When TxD has been low (Data0) for `BUS_ERR_CYC` cycles, bits 1 and 2 are loaded instead. A level held for fewer cycles loads nothing.
- R7: Per line (bit 0 plus, bit 1 minus): `open_flt` is high-side low-current AND low-side low-current. `vcc_short` is high-side low-current AND low-side high-current. `gnd_short` is high-side high-current AND low-side low-current.
- R8: `line_short` is loaded from `short_cmp` at the same instant, one qualification window after each TxD edge. A TxD change reaches the flag on the (`BUS_ERR_CYC`+3)th clock edge.
- R9: With normal mode, `txen_n` low and `bge` high held without a toggle, `en_tmo` rises on the (`TMO_CYC`+1)th clock edge after enabling, and `drv_en` then drops.
- R10: `en_tmo` clears on the next clock edge after either enable input toggles or `mode` leaves normal.
- R11: `err_sum` is the OR of `bus_err`, all current flags, `line_short`, `en_tmo` and `uv_io`.
- R12: `err_n` is low exactly when `err_sum` is set and `mode` is normal, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode: 00 off, 01 standby, 10 normal |
| txd | input | 1 | Transmit data line (asynchronous) |
| rxd | input | 1 | Receive data line (asynchronous) |
| txen_n | input | 1 | Transmit enable, active low |
| bge | input | 1 | Guardian enable, active high |
| cmp_lo | input | 4 | Low-current comparators, driver order as in R5 |
| cmp_hi | input | 4 | High-current comparators, driver order as in R5 |
| short_cmp | input | 1 | Line-to-line differential below short threshold |
| uv_io | input | 1 | I/O supply undervoltage flag |
| lo_flag | output | 4 | Sampled low-current flags |
| hi_flag | output | 4 | Sampled high-current flags |
| open_flt | output | 2 | Open line per line |
| vcc_short | output | 2 | Short to supply per line |
| gnd_short | output | 2 | Short to ground per line |
| line_short | output | 1 | Short between the lines |
| bus_err | output | 1 | Echo mismatch flag |
| en_tmo | output | 1 | Driver enable timeout flag |
| drv_en | output | 1 | Transmitter currently enabled |
| err_sum | output | 1 | OR of all error flags and `uv_io` |
| err_n | output | 1 | Active-low error pin |

## Verification
A TxD change needs two synchronizer cycles to become an edge. The window counter then clears, and a sampled flag lands on the (`BUS_ERR_CYC`+3)th clock edge. The line-short test samples one cycle before that edge and again right after it. The enable timeout is checked one cycle before and one cycle after the (`TMO_CYC`+1)th edge. Table-driven current tests and the echo tests wait a margin beyond the due cycle before checking. The summary and pin are combinational and are checked one cycle after a mode or undervoltage change.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_STBY = 2'b01,
        MODE_NORM = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    typedef enum logic {
        ECHO_IDLE = 1'b0,
        ECHO_PEND = 1'b1
    } echo_e;

    typedef enum logic [1:0] {
        TMO_IDLE    = 2'b00,
        TMO_ARMED   = 2'b01,
        TMO_EXPIRED = 2'b10
    } tmo_e;

    localparam int NUM_LINES = 2;
    localparam int NUM_DRV   = 2 * NUM_LINES;

endpackage

// File: rtl/bfd_sync.sv
module bfd_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta;
    logic [W-1:0] sync;
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '1;
            sync <= '1;
            prev <= '1;
        end else begin
            meta <= d;
            sync <= meta;
            prev <= sync;
        end
    end

    always_comb begin
        q    = sync;
        rise = sync & ~prev;
        fall = ~sync & prev;
    end
endmodule

// File: rtl/bfd_echo_fsm.sv
module bfd_echo_fsm
    import bfd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tx_edge,
    input  logic rx_edge,
    output logic miss,
    output logic ack
);
    echo_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       state <= ECHO_IDLE;
        else if (!active) state <= ECHO_IDLE;
        else              state <= nxt;
    end

    always_comb begin
        nxt  = state;
        miss = 1'b0;
        ack  = 1'b0;
        unique case (state)
            ECHO_IDLE: begin
                ack = tx_edge & rx_edge;
                if (tx_edge && !rx_edge) nxt = ECHO_PEND;
            end
            ECHO_PEND: begin
                ack  = rx_edge;
                miss = tx_edge & ~rx_edge;
                if (rx_edge && !tx_edge) nxt = ECHO_IDLE;
            end
            default: nxt = ECHO_IDLE;
        endcase
    end
endmodule

// File: rtl/bfd_window.sv
module bfd_window #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic edge_in,
    output logic sample
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);
    localparam logic [CW-1:0] TOP  = CW'(CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (!active || edge_in) cnt <= '0;
        else if (cnt != TOP)       cnt <= cnt + 1'b1;
    end

    always_comb sample = active & ~edge_in & (cnt == LAST);
endmodule

// File: rtl/bfd_enable_tmo.sv
module bfd_enable_tmo
    import bfd_pkg::*;
#(
    parameter int CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic norm,
    input  logic txen_n,
    input  logic bge,
    output logic expired
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    tmo_e          state, nxt;
    logic [CW-1:0] cnt;
    logic          txen_q, bge_q;
    logic          en_raw, toggle;

    always_comb begin
        en_raw = norm & ~txen_n & bge;
        toggle = (txen_n != txen_q) | (bge != bge_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txen_q <= 1'b1;
            bge_q  <= 1'b0;
        end else begin
            txen_q <= txen_n;
            bge_q  <= bge;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TMO_IDLE:    if (en_raw) nxt = TMO_ARMED;
            TMO_ARMED: begin
                if (toggle || !en_raw) nxt = TMO_IDLE;
                else if (cnt == LAST)  nxt = TMO_EXPIRED;
            end
            TMO_EXPIRED: if (toggle || !norm) nxt = TMO_IDLE;
            default:     nxt = TMO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TMO_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     cnt <= '0;
        else if (state == TMO_ARMED && nxt == TMO_ARMED) cnt <= cnt + 1'b1;
        else                                            cnt <= '0;
    end

    always_comb expired = (state == TMO_EXPIRED);
endmodule

// File: rtl/bfd_flag_unit.sv
module bfd_flag_unit
    import bfd_pkg::*;
#(
    parameter int BUS_ERR_CYC = 16,
    parameter int TMO_CYC     = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       txd,
    input  logic       rxd,
    input  logic       txen_n,
    input  logic       bge,
    input  logic [3:0] cmp_lo,
    input  logic [3:0] cmp_hi,
    input  logic       short_cmp,
    input  logic       uv_io,
    output logic [3:0] lo_flag,
    output logic [3:0] hi_flag,
    output logic [1:0] open_flt,
    output logic [1:0] vcc_short,
    output logic [1:0] gnd_short,
    output logic       line_short,
    output logic       bus_err,
    output logic       en_tmo,
    output logic       drv_en,
    output logic       err_sum,
    output logic       err_n
);
    // Drivers sampled during Data1 (plus high side, minus low side) and Data0.
    localparam logic [NUM_DRV-1:0] MASK_D1 = 4'b1001;
    localparam logic [NUM_DRV-1:0] MASK_D0 = 4'b0110;

    logic       norm, off;
    logic [1:0] sq, srise, sfall;
    logic       txd_s, tx_edge, sample;
    logic [1:0] miss, ack;
    logic [1:0] tx_e, rx_e;

    always_comb begin
        norm   = (mode_e'(mode) == MODE_NORM);
        off    = (mode_e'(mode) == MODE_OFF);
        drv_en = norm & ~txen_n & bge & ~en_tmo;
    end

    // index 0 = TxD, index 1 = RxD
    bfd_sync #(.W(2)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({rxd, txd}),
        .q   (sq),
        .rise(srise),
        .fall(sfall)
    );

    always_comb begin
        txd_s   = sq[0];
        tx_edge = srise[0] | sfall[0];
        tx_e    = {sfall[0], srise[0]};
        rx_e    = {sfall[1], srise[1]};
    end

    // polarity 0 = rising, polarity 1 = falling
    for (genvar p = 0; p < 2; p++) begin : g_echo
        bfd_echo_fsm u_echo (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (drv_en),
            .tx_edge(tx_e[p]),
            .rx_edge(rx_e[p]),
            .miss   (miss[p]),
            .ack    (ack[p])
        );
    end

    bfd_window #(.CYC(BUS_ERR_CYC)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (drv_en),
        .edge_in(tx_edge),
        .sample (sample)
    );

    bfd_enable_tmo #(.CYC(TMO_CYC)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .norm   (norm),
        .txen_n (txen_n),
        .bge    (bge),
        .expired(en_tmo)
    );

    logic [NUM_DRV-1:0] upd_mask;
    always_comb upd_mask = txd_s ? MASK_D1 : MASK_D0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_flag    <= '0;
            hi_flag    <= '0;
            line_short <= 1'b0;
            bus_err    <= 1'b0;
        end else if (off) begin
            lo_flag    <= '0;
            hi_flag    <= '0;
            line_short <= 1'b0;
            bus_err    <= 1'b0;
        end else if (drv_en) begin
            if (sample) begin
                lo_flag    <= (lo_flag & ~upd_mask) | (cmp_lo & upd_mask);
                hi_flag    <= (hi_flag & ~upd_mask) | (cmp_hi & upd_mask);
                line_short <= short_cmp;
            end
            if (|miss)     bus_err <= 1'b1;
            else if (|ack) bus_err <= 1'b0;
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        localparam int HS = 2 * l;
        localparam int LS = 2 * l + 1;
        always_comb begin
            open_flt[l]  = lo_flag[HS] & lo_flag[LS];
            vcc_short[l] = lo_flag[HS] & hi_flag[LS];
            gnd_short[l] = hi_flag[HS] & lo_flag[LS];
        end
    end

    always_comb begin
        err_sum = bus_err | (|lo_flag) | (|hi_flag) | line_short | en_tmo | uv_io;
        err_n   = ~(err_sum & norm);
    end
endmodule

// File: rtl/bfd_flag_unit_chk.sv
module bfd_flag_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic [3:0] lo_flag,
    input logic [3:0] hi_flag,
    input logic       line_short,
    input logic       bus_err,
    input logic       en_tmo,
    input logic       drv_en,
    input logic       err_sum,
    input logic       err_n
);
    // R1
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (lo_flag == 4'b0 && hi_flag == 4'b0 && !bus_err && !line_short && !en_tmo));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00 && !drv_en) |=> ($stable(lo_flag) && $stable(hi_flag) && $stable(bus_err) && $stable(line_short)));

    // R2
    buserr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> $past(drv_en));

    // R9
    tmo_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_tmo) |-> $past(drv_en));

    // R10
    tmo_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_tmo && mode != 2'b10) |=> !en_tmo);

    // R12
    errpin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> (mode == 2'b10 && err_sum));
endmodule

bind bfd_flag_unit bfd_flag_unit_chk i_bfd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .lo_flag   (lo_flag),
    .hi_flag   (hi_flag),
    .line_short(line_short),
    .bus_err   (bus_err),
    .en_tmo    (en_tmo),
    .drv_en    (drv_en),
    .err_sum   (err_sum),
    .err_n     (err_n)
);

// File: tb/test_bfd_flag_unit.sv
`timescale 1ns/1ps
module test_bfd_flag_unit;
    localparam int T   = 8;
    localparam int TMO = 300;
    localparam logic [1:0] M_OFF = 2'b00, M_STBY = 2'b01, M_NORM = 2'b10;

    typedef struct packed {
        logic       lvl;
        logic [3:0] clo;
        logic [3:0] chi;
        logic       sh;
        logic [3:0] elo;
        logic [3:0] ehi;
        logic       esh;
        logic [5:0] eder; // {open P, open M, vcc P, vcc M, gnd P, gnd M}
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, 4'b0010, 4'b0000, 1'b1, 4'b0010, 4'b0000, 1'b1, 6'b000000},
        '{1'b1, 4'b0001, 4'b1000, 1'b0, 4'b0011, 4'b1000, 1'b0, 6'b100000},
        '{1'b0, 4'b0100, 4'b0010, 1'b0, 4'b0101, 4'b1010, 1'b0, 6'b001100},
        '{1'b1, 4'b1111, 4'b0000, 1'b1, 4'b1101, 4'b0010, 1'b1, 6'b011000},
        '{1'b0, 4'b0000, 4'b1111, 1'b0, 4'b1001, 4'b0110, 1'b0, 6'b001001},
        '{1'b1, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0110, 1'b0, 6'b000000}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic [1:0] mode;
    logic txd, rxd, txen_n, bge, short_cmp, uv_io;
    logic [3:0] cmp_lo, cmp_hi;
    logic [3:0] lo_flag, hi_flag;
    logic [1:0] open_flt, vcc_short, gnd_short;
    logic line_short, bus_err, en_tmo, drv_en, err_sum, err_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bfd_flag_unit #(.BUS_ERR_CYC(T), .TMO_CYC(TMO)) i_bfd_flag_unit (
        .clk(clk), .rst_n(rst_n), .mode(mode), .txd(txd), .rxd(rxd),
        .txen_n(txen_n), .bge(bge), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
        .short_cmp(short_cmp), .uv_io(uv_io), .lo_flag(lo_flag),
        .hi_flag(hi_flag), .open_flt(open_flt), .vcc_short(vcc_short),
        .gnd_short(gnd_short), .line_short(line_short), .bus_err(bus_err),
        .en_tmo(en_tmo), .drv_en(drv_en), .err_sum(err_sum), .err_n(err_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic kick();
        txen_n = 1'b1;
        tick(1);
        txen_n = 1'b0;
        tick(1);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode = M_OFF; txd = 1'b1; rxd = 1'b1;
        txen_n = 1'b1; bge = 1'b1; short_cmp = 1'b0; uv_io = 1'b0;
        cmp_lo = 4'b0; cmp_hi = 4'b0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 reset flags", {lo_flag, hi_flag, line_short, bus_err, en_tmo}, 0);
        chk("R12 reset pin", err_n, 1);

        mode = M_NORM;
        kick();
        tick(T + 6);

        // R5 R6 R7 R8 table walk, RxD echoes TxD
        for (int i = 0; i < 6; i++) begin
            cmp_lo = VEC[i].clo; cmp_hi = VEC[i].chi; short_cmp = VEC[i].sh;
            txd = VEC[i].lvl; rxd = VEC[i].lvl;
            tick(T + 6);
            chk(VEC[i].lvl ? "R5 lo_flag" : "R6 lo_flag", lo_flag, VEC[i].elo);
            chk(VEC[i].lvl ? "R5 hi_flag" : "R6 hi_flag", hi_flag, VEC[i].ehi);
            chk("R8 line_short", line_short, VEC[i].esh);
            chk("R7 derived", {open_flt[0], open_flt[1], vcc_short[0], vcc_short[1],
                               gnd_short[0], gnd_short[1]}, VEC[i].eder);
            chk("R3 echoed edges", bus_err, 0);
        end

        // R11 R12 with hi_flag nonzero in normal mode
        chk("R11 summary", err_sum, 1);
        chk("R12 pin normal", err_n, 0);

        // R4 standby: no flag moves
        mode = M_STBY;
        cmp_lo = 4'b1111; cmp_hi = 4'b0000; short_cmp = 1'b1;
        tick(1);
        txd = 1'b0;
        tick(T + 10);
        chk("R4 lo hold", lo_flag, 4'b0000);
        chk("R4 hi hold", hi_flag, 4'b0110);
        chk("R4 short hold", line_short, 0);
        chk("R4 buserr hold", bus_err, 0);
        chk("R12 pin standby", err_n, 1);
        txd = 1'b1;
        tick(4);

        // R1 power off clears
        mode = M_OFF;
        tick(2);
        chk("R1 off flags", {lo_flag, hi_flag, line_short, bus_err, en_tmo}, 0);
        chk("R11 summary clear", err_sum, 0);

        // R6 short Data0 pulse samples nothing
        mode = M_NORM;
        short_cmp = 1'b0; cmp_lo = 4'b0110; cmp_hi = 4'b0000;
        kick();
        tick(T + 6);
        txd = 1'b0; rxd = 1'b0;
        tick(3);
        txd = 1'b1; rxd = 1'b1;
        tick(T + 6);
        chk("R6 short window", lo_flag, 4'b0000);

        // R8 exact timing
        short_cmp = 1'b1;
        txd = 1'b0; rxd = 1'b0;
        tick(T + 2);
        chk("R8 before due", line_short, 0);
        tick(1);
        chk("R8 at due", line_short, 1);
        txd = 1'b1; rxd = 1'b1; short_cmp = 1'b0;
        tick(T + 6);

        // R2 missing echo, R3 recovery
        mode = M_OFF; tick(2); mode = M_NORM;
        kick();
        tick(4);
        txd = 1'b0; tick(4);
        txd = 1'b1; tick(4);
        chk("R2 single miss", bus_err, 0);
        txd = 1'b0; tick(4);
        txd = 1'b1; tick(4);
        chk("R2 two unechoed edges", bus_err, 1);
        rxd = 1'b0; tick(4);
        chk("R3 echo clears", bus_err, 0);
        rxd = 1'b1; tick(4);

        // R9 timeout exact timing
        mode = M_OFF; tick(2); mode = M_NORM;
        txen_n = 1'b1; tick(1);
        txen_n = 1'b0;
        tick(TMO);
        chk("R9 before due", en_tmo, 0);
        chk("R9 drv before", drv_en, 1);
        tick(1);
        chk("R9 at due", en_tmo, 1);
        chk("R9 drv off", drv_en, 0);

        // R10 guardian toggle clears
        bge = 1'b0; tick(1);
        chk("R10 bge toggle", en_tmo, 0);
        bge = 1'b1;
        tick(TMO + 4);
        chk("R9 re-expired", en_tmo, 1);
        mode = M_STBY; tick(1);
        chk("R10 leave normal", en_tmo, 0);

        // R11 R12 undervoltage
        mode = M_OFF; tick(2);
        mode = M_STBY; uv_io = 1'b1; tick(1);
        chk("R11 uv summary", err_sum, 1);
        chk("R12 uv standby pin", err_n, 1);
        mode = M_NORM; tick(1);
        chk("R12 uv normal pin", err_n, 0);
        uv_io = 1'b0; tick(1);
        chk("R11 uv gone", err_sum, 0);
        chk("R12 pin released", err_n, 1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule